// File: doc/BRIEF.md
# Monochrome Raster Scan Generator

This block produces the raster timing for a monochrome CRT and turns a 1-bit-per-pixel frame buffer into a serial pixel stream. It counts pixel clocks in 16-pixel word slots, counts word slots within a line and counts lines within a frame. Each position in the raster is classified as display, blank, or sync level. For every displayed word it reads one 16-bit word from memory and shifts that word out one bit per clock. The pixel clock is assumed to run at twice the host processor rate. This block does not care about that ratio, because it counts only its own clock.

Reads go out on a valid/ready request channel. When `mem_req_valid` is high, the block holds `mem_req_addr` stable until `mem_req_ready` is seen, or until the word slot that carries the request ends. In that second case the request is withdrawn. Read data returns on a valid-only response channel, which has no back-pressure. The block accepts the first response that arrives after its request was accepted, provided it arrives within the same word slot.

Two inputs decide where the frame buffer lives. A buffer-select input picks the primary or the alternate screen base, and a memory-size strap adds a fixed offset to that base. Both are sampled only during reset and at the start of the last line of each frame.

Top module: `vsg_top`

## Requirements
- R1: A line lasts LINE_WORDS slots of 16 clocks each, and a frame lasts FRAME_LINES lines. After reset, raster position 0 is line 0, word 0, pixel 0, and the position advances by one pixel each clock.
- R2: On lines 0 to ACTIVE_LINES-1:
  - words 0 to ACTIVE_WORDS-1 are display (`blank_out`=0, `sync_out`=0);
  - words HS_START to HS_START+HS_LEN-1 have `sync_out`=1 and `blank_out`=1;
  - every other word has `blank_out`=1 and `sync_out`=0.
- R3: On lines VS_START to VS_START+VS_LEN-1 the sync pattern is inverted. `blank_out`=1 throughout, and `sync_out`=1 everywhere except words HS_START to HS_START+HS_LEN-1, where it is 0.
- R4: Every other line is blank (`blank_out`=1). On those lines `sync_out`=1 only in words HS_START to HS_START+HS_LEN-1.
- R5: A read request for display word w is raised in the slot just before that word. For word 0 of a line, that is the last slot of the previous line. The request stays asserted with a stable address until it is accepted or the slot ends. At most one request is accepted per slot, and no request is raised in any other slot.
- R6: The word address read for line L, word w equals base + L*ACTIVE_WORDS + w. The address therefore steps by one after every fetch and continues across line boundaries.
- R7: Pixels of a fetched word come out least significant bit first, from data bit 0 to data bit 15, in the 16 clocks of its display slot.
- R8: If no response for the accepted request arrives within the request's slot, the pixels of that word are all 0, while `blank_out` stays 0.
- R9: A response (`mem_rd_valid`=1) that arrives while no accepted request of the current slot is waiting has no effect on the pixels.
- R10: The byte base is 0x1A700 when `buf_sel`=0 and 0x12700 when `buf_sel`=1. When `mem_big`=1, 0x60000 is added. The word base is the byte base divided by 2.
- R11: `buf_sel` and `mem_big` are sampled at every reset clock and in the first clock of line FRAME_LINES-1. Changes at any other time do not affect the addresses.
- R12: Reset is synchronous and active high. While it is held, the outputs show position 0 as display with pixel 0, and the base is reloaded. Word 0 of the first line after reset shows pixel 0 because it has no prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_sel | input | 1 | 0: primary screen base, 1: alternate screen base |
| mem_big | input | 1 | Adds the large-memory offset to the base |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_rd_valid | input | 1 | Read data valid (no back-pressure) |
| mem_rd_data | input | WORD_PIX | Read data word |
| pix_out | output | 1 | Serial pixel |
| blank_out | output | 1 | High outside display words |
| sync_out | output | 1 | Composite sync level |

## Verification
The bench keeps 16-pixel words and the default base addresses, but shrinks the raster. It uses 12-word lines with 4 display words and horizontal sync at words 7 and 8. Frames are 20 lines, with 8 active lines and vertical sync on lines 13 to 15. A frame is therefore 3840 clocks, so a short run covers many frame wraps, base reloads and vertical-sync lines. The smaller raster also places word-0 prefetches that cross a line end and the frame wrap within reach many times over. The memory model uses random ready and latency, so responses arrive in time, arrive late, or never arrive.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    ROW_SHOW  = 2'd0,
    ROW_VSYNC = 2'd1,
    ROW_IDLE  = 2'd2
  } row_kind_t;
endpackage

// File: rtl/vsg_timing.sv
module vsg_timing #(
  parameter int WORD_PIX    = 16,
  parameter int LINE_WORDS  = 44,
  parameter int FRAME_LINES = 370
) (
  input  logic                           clk,
  input  logic                           rst,
  output logic [$clog2(LINE_WORDS)-1:0]  word_idx,
  output logic [$clog2(FRAME_LINES)-1:0] row_idx,
  output logic                           slot_last,
  output logic [$clog2(LINE_WORDS)-1:0]  nxt_word,
  output logic [$clog2(FRAME_LINES)-1:0] nxt_row,
  output logic                           frame_tail
);
  localparam int BIT_W = $clog2(WORD_PIX);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int ROW_W = $clog2(FRAME_LINES);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_PIX - 1);
  localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(LINE_WORDS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(FRAME_LINES - 1);

  logic [BIT_W-1:0] bit_idx;
  logic             word_last;

  assign slot_last  = (bit_idx == LAST_BIT);
  assign word_last  = (word_idx == LAST_WORD);
  assign nxt_word   = word_last ? '0 : word_idx + 1'b1;
  assign nxt_row    = word_last ? ((row_idx == LAST_ROW) ? '0 : row_idx + 1'b1) : row_idx;
  assign frame_tail = (row_idx == LAST_ROW) && (word_idx == '0) && (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx  <= '0;
      word_idx <= '0;
      row_idx  <= '0;
    end else if (slot_last) begin
      bit_idx  <= '0;
      word_idx <= nxt_word;
      row_idx  <= nxt_row;
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_last && word_last && row_idx == LAST_ROW) |=> (row_idx == '0 && word_idx == '0 && bit_idx == '0));

  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!slot_last) |=> ($stable(word_idx) && $stable(row_idx)));
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
  import vsg_pkg::*;
#(
  parameter int LINE_WORDS   = 44,
  parameter int FRAME_LINES  = 370,
  parameter int ACTIVE_WORDS = 32,
  parameter int ACTIVE_LINES = 342,
  parameter int HS_START     = 36,
  parameter int HS_LEN       = 2,
  parameter int VS_START     = 353,
  parameter int VS_LEN       = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [$clog2(LINE_WORDS)-1:0]  word_idx,
  input  logic [$clog2(FRAME_LINES)-1:0] row_idx,
  output logic                           show,
  output logic                           sync,
  output logic                           blank
);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int ROW_W = $clog2(FRAME_LINES);

  row_kind_t kind;
  logic      hs_word;

  assign hs_word = (word_idx >= WRD_W'(HS_START)) && (word_idx < WRD_W'(HS_START + HS_LEN));

  always_comb begin
    if (row_idx < ROW_W'(ACTIVE_LINES))
      kind = ROW_SHOW;
    else if ((row_idx >= ROW_W'(VS_START)) && (row_idx < ROW_W'(VS_START + VS_LEN)))
      kind = ROW_VSYNC;
    else
      kind = ROW_IDLE;
  end

  assign show  = (kind == ROW_SHOW) && (word_idx < WRD_W'(ACTIVE_WORDS));
  assign blank = !show;
  assign sync  = (kind == ROW_VSYNC) ? !hs_word : hs_word;

  // R2
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (rst) sync |-> blank);
endmodule

// File: rtl/vsg_fetch.sv
module vsg_fetch #(
  parameter int          WORD_PIX     = 16,
  parameter int          LINE_WORDS   = 44,
  parameter int          FRAME_LINES  = 370,
  parameter int          ACTIVE_WORDS = 32,
  parameter int          ACTIVE_LINES = 342,
  parameter int          ADDR_W       = 18,
  parameter logic [31:0] PRI_BYTE     = 32'h1A700,
  parameter logic [31:0] ALT_BYTE     = 32'h12700,
  parameter logic [31:0] BIG_BYTE     = 32'h60000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           slot_last,
  input  logic [$clog2(LINE_WORDS)-1:0]  nxt_word,
  input  logic [$clog2(FRAME_LINES)-1:0] nxt_row,
  input  logic                           frame_tail,
  input  logic                           buf_sel,
  input  logic                           mem_big,
  output logic                           req_valid,
  input  logic                           req_ready,
  output logic [ADDR_W-1:0]              req_addr,
  input  logic                           rd_valid,
  input  logic [WORD_PIX-1:0]            rd_data,
  output logic                           load_ok,
  output logic [WORD_PIX-1:0]            load_data
);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int ROW_W = $clog2(FRAME_LINES);
  localparam logic [ADDR_W-1:0] PRI_W = ADDR_W'(PRI_BYTE >> 1);
  localparam logic [ADDR_W-1:0] ALT_W = ADDR_W'(ALT_BYTE >> 1);
  localparam logic [ADDR_W-1:0] BIG_W = ADDR_W'(BIG_BYTE >> 1);

  logic [ADDR_W-1:0]   base_pick, base_lat, row_off;
  logic                pf_slot, req_done, hold_vld;
  logic [WORD_PIX-1:0] hold_data;

  assign base_pick = (buf_sel ? ALT_W : PRI_W) + (mem_big ? BIG_W : '0);
  assign pf_slot   = (nxt_row < ROW_W'(ACTIVE_LINES)) && (nxt_word < WRD_W'(ACTIVE_WORDS));
  assign row_off   = ADDR_W'(nxt_row) * ADDR_W'(ACTIVE_WORDS);
  assign req_addr  = base_lat + row_off + ADDR_W'(nxt_word);
  assign req_valid = pf_slot && !req_done;
  assign load_ok   = pf_slot && (hold_vld || (rd_valid && req_done));
  assign load_data = hold_vld ? hold_data : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lat  <= base_pick;
      req_done  <= 1'b0;
      hold_vld  <= 1'b0;
      hold_data <= '0;
    end else begin
      if (frame_tail) base_lat <= base_pick;
      if (slot_last) begin
        req_done <= 1'b0;
        hold_vld <= 1'b0;
      end else begin
        if (req_valid && req_ready) req_done <= 1'b1;
        if (rd_valid && req_done && !hold_vld) begin
          hold_vld  <= 1'b1;
          hold_data <= rd_data;
        end
      end
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !slot_last) |=> (req_valid && $stable(req_addr)));

  // R5
  one_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !slot_last) |=> !req_valid);
endmodule

// File: rtl/vsg_serial.sv
module vsg_serial #(
  parameter int WORD_PIX = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_last,
  input  logic                load_ok,
  input  logic [WORD_PIX-1:0] load_data,
  output logic                pix_bit
);
  logic [WORD_PIX-1:0] sh;
  logic                ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      ok <= 1'b0;
    end else if (slot_last) begin
      sh <= load_data;
      ok <= load_ok;
    end else begin
      sh <= {1'b0, sh[WORD_PIX-1:1]};
    end
  end

  assign pix_bit = ok & sh[0];

  // R7
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_last && load_ok) |=> (pix_bit == $past(load_data[0])));

  // R8
  miss_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_last && !load_ok) |=> !pix_bit);
endmodule

// File: rtl/vsg_top.sv
module vsg_top #(
  parameter int          WORD_PIX     = 16,
  parameter int          LINE_WORDS   = 44,
  parameter int          FRAME_LINES  = 370,
  parameter int          ACTIVE_WORDS = 32,
  parameter int          ACTIVE_LINES = 342,
  parameter int          HS_START     = 36,
  parameter int          HS_LEN       = 2,
  parameter int          VS_START     = 353,
  parameter int          VS_LEN       = 3,
  parameter int          ADDR_W       = 18,
  parameter logic [31:0] PRI_BYTE     = 32'h1A700,
  parameter logic [31:0] ALT_BYTE     = 32'h12700,
  parameter logic [31:0] BIG_BYTE     = 32'h60000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                buf_sel,
  input  logic                mem_big,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rd_valid,
  input  logic [WORD_PIX-1:0] mem_rd_data,
  output logic                pix_out,
  output logic                blank_out,
  output logic                sync_out
);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int ROW_W = $clog2(FRAME_LINES);

  logic [WRD_W-1:0]    word_idx, nxt_word;
  logic [ROW_W-1:0]    row_idx, nxt_row;
  logic                slot_last, frame_tail, show, pix_bit, load_ok;
  logic [WORD_PIX-1:0] load_data;

  vsg_timing #(
    .WORD_PIX(WORD_PIX), .LINE_WORDS(LINE_WORDS), .FRAME_LINES(FRAME_LINES)
  ) u_timing (
    .clk(clk), .rst(rst), .word_idx(word_idx), .row_idx(row_idx),
    .slot_last(slot_last), .nxt_word(nxt_word), .nxt_row(nxt_row),
    .frame_tail(frame_tail)
  );

  vsg_decode #(
    .LINE_WORDS(LINE_WORDS), .FRAME_LINES(FRAME_LINES),
    .ACTIVE_WORDS(ACTIVE_WORDS), .ACTIVE_LINES(ACTIVE_LINES),
    .HS_START(HS_START), .HS_LEN(HS_LEN), .VS_START(VS_START), .VS_LEN(VS_LEN)
  ) u_decode (
    .clk(clk), .rst(rst), .word_idx(word_idx), .row_idx(row_idx),
    .show(show), .sync(sync_out), .blank(blank_out)
  );

  vsg_fetch #(
    .WORD_PIX(WORD_PIX), .LINE_WORDS(LINE_WORDS), .FRAME_LINES(FRAME_LINES),
    .ACTIVE_WORDS(ACTIVE_WORDS), .ACTIVE_LINES(ACTIVE_LINES), .ADDR_W(ADDR_W),
    .PRI_BYTE(PRI_BYTE), .ALT_BYTE(ALT_BYTE), .BIG_BYTE(BIG_BYTE)
  ) u_fetch (
    .clk(clk), .rst(rst), .slot_last(slot_last), .nxt_word(nxt_word),
    .nxt_row(nxt_row), .frame_tail(frame_tail), .buf_sel(buf_sel),
    .mem_big(mem_big), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_addr(mem_req_addr), .rd_valid(mem_rd_valid), .rd_data(mem_rd_data),
    .load_ok(load_ok), .load_data(load_data)
  );

  vsg_serial #(.WORD_PIX(WORD_PIX)) u_serial (
    .clk(clk), .rst(rst), .slot_last(slot_last), .load_ok(load_ok),
    .load_data(load_data), .pix_bit(pix_bit)
  );

  assign pix_out = show & pix_bit;

  // R8
  pix_visible_chk: assert property (@(posedge clk) disable iff (rst) pix_out |-> !blank_out);
endmodule

// File: tb/tb_vsg_top.sv
`timescale 1ns/1ps
module tb_vsg_top;
  localparam int WP = 16, LW = 12, FL = 20, AW = 4, AL = 8;
  localparam int HSS = 7, HSL = 2, VSS = 13, VSL = 3, AWID = 18;
  localparam int LINE_PIX = WP * LW;
  localparam int FRAME_PIX = LINE_PIX * FL;

  logic clk = 1'b0, rst = 1'b1, buf_sel = 1'b0, mem_big = 1'b0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_rd_valid = 1'b0;
  logic [AWID-1:0] mem_req_addr;
  logic [WP-1:0]   mem_rd_data = '0;
  logic pix_out, blank_out, sync_out;

  vsg_top #(
    .WORD_PIX(WP), .LINE_WORDS(LW), .FRAME_LINES(FL), .ACTIVE_WORDS(AW),
    .ACTIVE_LINES(AL), .HS_START(HSS), .HS_LEN(HSL), .VS_START(VSS),
    .VS_LEN(VSL), .ADDR_W(AWID)
  ) dut (.*);

  always #4 clk = ~clk;

  int t = 0;
  always @(posedge clk) t <= rst ? 0 : t + 1;

  int n_chk = 0, n_bad = 0;
  int ready_pct = 100, lat_max = 4;
  bit spurious = 0, wiggle = 0;

  logic [AWID-1:0] exp_base;
  bit cur_ok, next_ok, acc_this_slot, pending;
  logic [WP-1:0] cur_data, next_data;
  logic [AWID-1:0] paddr;
  int pcnt, acc_slot;

  function automatic logic [AWID-1:0] base_of(input logic s, input logic b);
    logic [31:0] by;
    by = (s ? 32'h12700 : 32'h1A700) + (b ? 32'h60000 : 32'h0);
    return AWID'(by >> 1);
  endfunction

  function automatic logic [WP-1:0] mem_word(input logic [AWID-1:0] a);
    return (a[15:0] * 16'h9E37) ^ 16'hA5C3 ^ {a[17:16], 14'b0};
  endfunction

  function automatic bit is_hs(input int w);
    return (w >= HSS) && (w < HSS + HSL);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  task automatic clear_state();
    cur_ok = 0; next_ok = 0; acc_this_slot = 0; pending = 0;
    cur_data = '0; next_data = '0; pcnt = 0; acc_slot = -1;
  endtask

  task automatic do_reset(input logic s, input logic b);
    buf_sel = s; mem_big = b; rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      mem_req_ready = 1'b0; mem_rd_valid = 1'b0;
    end
    clear_state();
    exp_base = base_of(s, b);
    // R12: reset shows position 0 as display, pixel dark
    check("R12 pix", 32'(pix_out), 0);
    check("R12 blank", 32'(blank_out), 0);
    check("R12 sync", 32'(sync_out), 0);
    rst = 1'b0;
  endtask

  task automatic step();
    int l, px, w, b, nw, nl, slot;
    bit disp, e_sync, pf, e_pix, delivered;
    @(negedge clk);
    l = (t / LINE_PIX) % FL; px = t % LINE_PIX; w = px / WP; b = px % WP;
    slot = t / WP;
    disp = (l < AL) && (w < AW);
    if (l < AL) e_sync = is_hs(w);
    else if (l >= VSS && l < VSS + VSL) e_sync = !is_hs(w);
    else e_sync = is_hs(w);
    // R1 R2 R3 R4: raster decode
    if (l < AL) begin
      check("R1 R2 blank", 32'(blank_out), 32'(!disp));
      check("R2 sync", 32'(sync_out), 32'(e_sync));
    end else if (l >= VSS && l < VSS + VSL) begin
      check("R3 blank", 32'(blank_out), 1);
      check("R3 sync", 32'(sync_out), 32'(e_sync));
    end else begin
      check("R4 blank", 32'(blank_out), 1);
      check("R4 sync", 32'(sync_out), 32'(e_sync));
    end
    // R7 R8 R9: serial pixels
    e_pix = disp && cur_ok && cur_data[b];
    check(cur_ok ? "R7 pix" : "R8 R9 pix", 32'(pix_out), 32'(e_pix));
    // R5 R6 R10 R11: requests
    nw = (w == LW - 1) ? 0 : w + 1;
    nl = (w == LW - 1) ? ((l == FL - 1) ? 0 : l + 1) : l;
    pf = (nl < AL) && (nw < AW);
    check("R5 req_valid", 32'(mem_req_valid), 32'(pf && !acc_this_slot));
    if (mem_req_valid)
      check("R6 R10 R11 addr", 32'(mem_req_addr), 32'(exp_base + AWID'(nl * AW + nw)));
    if (l == FL - 1 && px == 0) exp_base = base_of(buf_sel, mem_big);
    // memory response
    delivered = 0; mem_rd_valid = 1'b0; mem_rd_data = WP'($urandom);
    if (pending) begin
      pcnt--;
      if (pcnt == 0) begin
        mem_rd_valid = 1'b1; mem_rd_data = mem_word(paddr);
        pending = 0; delivered = 1;
        if (acc_slot == slot) begin next_ok = 1; next_data = mem_word(paddr); end
      end
    end
    if (!delivered && !pending && spurious && ($urandom % 8 == 0)) mem_rd_valid = 1'b1;
    // memory accept
    mem_req_ready = 1'b0;
    if (mem_req_valid && !pending && ($urandom % 100 < 32'(ready_pct))) begin
      mem_req_ready = 1'b1; pending = 1; paddr = mem_req_addr;
      pcnt = 1 + int'($urandom % 32'(lat_max));
      acc_this_slot = 1; acc_slot = slot;
    end
    if (wiggle && ($urandom % 300 == 0)) begin
      buf_sel = $urandom % 2; mem_big = $urandom % 2;
    end
    if (b == WP - 1) begin
      cur_ok = next_ok; cur_data = next_data; next_ok = 0; acc_this_slot = 0;
    end
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    clear_state();
    do_reset(1'b0, 1'b0);
    // random ready and latency, late data, stray responses
    ready_pct = 60; lat_max = 20; spurious = 1;
    repeat (2 * FRAME_PIX) step();
    // memory never ready: dark display words
    ready_pct = 0; spurious = 0;
    repeat (FRAME_PIX) step();
    // base inputs changing at random times
    ready_pct = 90; lat_max = 8; wiggle = 1;
    repeat (3 * FRAME_PIX) step();
    wiggle = 0;
    // reset into alternate base with large memory
    do_reset(1'b1, 1'b1);
    ready_pct = 100; lat_max = 4;
    repeat (FRAME_PIX + 200) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule